// File: doc/BRIEF.md
# Infrared Carrier Generator

This block produces a modulation carrier on one output pin. The carrier is derived from the block clock by an integer divide ratio of the form base × 2^n, where the base is 2 or 3 and the exponent n is a small field (0 to 3 with the default width). The high time of each carrier period is either half of the period or one third of it. Which of the two is used depends partly on a duty select input and partly on the ratio. Ratios with base 2 are always symmetric. The ratio 3 is always one third high. The other base-3 ratios follow the duty select.

In carrier mode, a data/enable bit gates the carrier. While the bit is low, the pin is low and the period counter is held at its start. Each burst therefore begins with a full high phase in the cycle where the bit rises. In level mode, the pin simply follows the data bit. The divider configuration is sampled while the carrier is idle. During a burst it is sampled only at the end of each period, so a change made during a burst never produces a truncated or stretched period.

Top module: `ircg_carrier_gen`

## Requirements
- R1: In carrier mode with `data_en` held high, `pin_out` repeats with a period of R clock cycles. R = 2·2^n when `div_base3`=0 and R = 3·2^n when `div_base3`=1, where n is `div_exp`.
- R2: With `div_base3`=0, `pin_out` is high for the first 2^n cycles of each period and low for the remaining cycles.
- R3: With `div_base3`=1 and `div_exp`=0, `pin_out` is high for the first cycle of every three, for either value of `duty_third`.
- R4: With `div_base3`=1, `div_exp`>0 and `duty_third`=1, `pin_out` is high for the first 2^n cycles of each period.
- R5: With `div_base3`=1, `div_exp`>0 and `duty_third`=0, `pin_out` is high for the first 3·2^(n-1) cycles of each period.
- R6: With `div_base3`=0, the value of `duty_third` has no effect on `pin_out`.
- R7: In carrier mode (`carrier_mode`=1), `pin_out` is 0 whenever `data_en` is 0. In the same cycle that `data_en` returns to 1, the pin is high, and the next period starts from its first cycle.
- R8: In level mode (`carrier_mode`=0), `pin_out` equals `data_en` in every cycle.
- R9: A configuration change applied during a burst takes effect only after the current period completes. The configuration must be present for one clock edge before `data_en` rises for it to govern a new burst.
- R10: In carrier mode, `pin_out` is 0 while `rst_n` is low. After release, a burst with the reset configuration (ratio 2) starts at its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the carrier source |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_base3 | input | 1 | Divider base: 0 selects 2, 1 selects 3 |
| div_exp | input | EXP_W | Divider exponent n |
| duty_third | input | 1 | 1 requests one-third duty where the ratio allows it |
| carrier_mode | input | 1 | 1 selects carrier output, 0 selects level output |
| data_en | input | 1 | Data bit: carrier gate or direct level |
| pin_out | output | 1 | Output pin value |

## Verification
On every cycle, the assertions check the following properties. The pin is low when the gate is low in carrier mode, and it mirrors the data bit in level mode. The pin's high phase matches the active ratio and duty at the current period position. The period counter never exceeds the active ratio. The active configuration changes during a burst only right after the last cycle of a period. Other behaviour is visible only in the bench's scenarios: the absolute period and high time seen at the pin for each ratio and duty setting, and the fact that the duty select is ignored for base-2 ratios. The same applies to the restart on a new burst and the delayed effect of a configuration change written mid-period.

// File: rtl/ircg_pkg.sv
package ircg_pkg;

   // Output behaviour selected by the mode input.
   typedef enum logic {
      IRCG_LEVEL   = 1'b0,
      IRCG_CARRIER = 1'b1
   } ircg_mode_e;

   // Divider base encoding.
   typedef enum logic {
      IRCG_BASE_TWO   = 1'b0,
      IRCG_BASE_THREE = 1'b1
   } ircg_base_e;

   // Counter width large enough for the largest ratio 3 * 2^(2^exp_w - 1).
   function automatic int ircg_cnt_width(input int exp_w);
      int max_ratio;
      max_ratio = 3 << ((1 << exp_w) - 1);
      return $clog2(max_ratio);
   endfunction

endpackage

// File: rtl/ircg_cfg_hold.sv
module ircg_cfg_hold #(
   parameter int EXP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             base3_in,
   input  logic [EXP_W-1:0] exp_in,
   input  logic             third_in,
   output logic             base3_q,
   output logic [EXP_W-1:0] exp_q,
   output logic             third_q
);

   // Active divider settings; refreshed only when the caller allows it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base3_q <= 1'b0;
         exp_q   <= '0;
         third_q <= 1'b0;
      end else if (load) begin
         base3_q <= base3_in;
         exp_q   <= exp_in;
         third_q <= third_in;
      end
   end

endmodule

// File: rtl/ircg_period_ctr.sv
module ircg_period_ctr #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wrap,
   output logic [CNT_W-1:0] cnt_q
);

   // Phase within the current carrier period; parked at zero when idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/ircg_duty_cmp.sv
module ircg_duty_cmp #(
   parameter int EXP_W = 2,
   parameter int CNT_W = 5
) (
   input  logic             base3,
   input  logic [EXP_W-1:0] exp_sel,
   input  logic             third,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] last_phase,
   output logic             phase_high
);

   localparam int NUM_EXP = 1 << EXP_W;

   logic [CNT_W-1:0] last2_tbl  [NUM_EXP];
   logic [CNT_W-1:0] last3_tbl  [NUM_EXP];
   logic [CNT_W-1:0] hi2_tbl    [NUM_EXP];
   logic [CNT_W-1:0] hi3t_tbl   [NUM_EXP];
   logic [CNT_W-1:0] hi3h_tbl   [NUM_EXP];

   // One set of constants per exponent value.
   for (genvar gi = 0; gi < NUM_EXP; gi++) begin : g_exp
      localparam int LAST2 = (2 << gi) - 1;
      localparam int LAST3 = (3 << gi) - 1;
      localparam int HI2   = 1 << gi;
      localparam int HI3T  = 1 << gi;
      // ratio 3 has no symmetric option, so its half setting falls back to 1/3
      localparam int HI3H  = (gi == 0) ? 1 : (3 << (gi - 1));
      assign last2_tbl[gi] = CNT_W'(LAST2);
      assign last3_tbl[gi] = CNT_W'(LAST3);
      assign hi2_tbl[gi]   = CNT_W'(HI2);
      assign hi3t_tbl[gi]  = CNT_W'(HI3T);
      assign hi3h_tbl[gi]  = CNT_W'(HI3H);
   end

   logic [CNT_W-1:0] hi_len;

   always_comb begin
      if (base3) begin
         last_phase = last3_tbl[exp_sel];
         hi_len     = third ? hi3t_tbl[exp_sel] : hi3h_tbl[exp_sel];
      end else begin
         last_phase = last2_tbl[exp_sel];
         hi_len     = hi2_tbl[exp_sel];
      end
   end

   assign phase_high = (cnt < hi_len);

endmodule

// File: rtl/ircg_carrier_gen.sv
module ircg_carrier_gen #(
   parameter int EXP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_base3,
   input  logic [EXP_W-1:0] div_exp,
   input  logic             duty_third,
   input  logic             carrier_mode,
   input  logic             data_en,
   output logic             pin_out
);

   import ircg_pkg::*;

   localparam int CNT_W = ircg_cnt_width(EXP_W);

   if (EXP_W < 1 || EXP_W > 3) begin : g_bad_exp_w
      $error("ircg_carrier_gen: EXP_W must lie in 1..3");
   end

   ircg_mode_e       mode;
   logic             run;
   logic             wrap;
   logic             load;
   logic             act_base3;
   logic [EXP_W-1:0] act_exp;
   logic             act_third;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_phase;
   logic             phase_high;

   assign mode = ircg_mode_e'(carrier_mode);
   assign run  = rst_n && (mode == IRCG_CARRIER) && data_en;
   assign wrap = run && (cnt_q == last_phase);
   assign load = !run || wrap;

   ircg_cfg_hold #(.EXP_W(EXP_W)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .base3_in (div_base3),
      .exp_in   (div_exp),
      .third_in (duty_third),
      .base3_q  (act_base3),
      .exp_q    (act_exp),
      .third_q  (act_third)
   );

   ircg_period_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .wrap  (wrap),
      .cnt_q (cnt_q)
   );

   ircg_duty_cmp #(.EXP_W(EXP_W), .CNT_W(CNT_W)) cmp_i (
      .base3      (act_base3),
      .exp_sel    (act_exp),
      .third      (act_third),
      .cnt        (cnt_q),
      .last_phase (last_phase),
      .phase_high (phase_high)
   );

   assign pin_out = (mode == IRCG_CARRIER) ? (run && phase_high) : data_en;

endmodule

// File: rtl/ircg_carrier_gen_chk.sv
module ircg_carrier_gen_chk #(
   parameter int EXP_W = 2,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             carrier_mode,
   input logic             data_en,
   input logic             pin_out,
   input logic [CNT_W-1:0] cnt_q,
   input logic             act_base3,
   input logic [EXP_W-1:0] act_exp,
   input logic             act_third
);

   function automatic int period_of(input logic b3, input logic [EXP_W-1:0] e);
      return (b3 ? 3 : 2) * (1 << e);
   endfunction

   logic bursting;
   logic [EXP_W+1:0] cfg_vec;
   assign bursting = carrier_mode && data_en;
   assign cfg_vec  = {act_base3, act_third, act_exp};

   assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier_mode && !data_en) |-> !pin_out);

   assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_mode |-> (pin_out == data_en));

   assert_phase_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bursting |-> (int'(cnt_q) < period_of(act_base3, act_exp)));

   assert_base2_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bursting && !act_base3) |-> (pin_out == (int'(cnt_q) < (1 << act_exp))));

   assert_ratio3_third_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bursting && act_base3 && act_exp == '0) |-> (pin_out == (cnt_q == '0)));

   assert_base3_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bursting && act_base3 && act_exp != '0 && act_third)
      |-> (pin_out == (int'(cnt_q) < (1 << act_exp))));

   assert_base3_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bursting && act_base3 && act_exp != '0 && !act_third)
      |-> (pin_out == (2 * int'(cnt_q) < period_of(1'b1, act_exp))));

   assert_cfg_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bursting && $past(bursting) && $past(rst_n) && cfg_vec != $past(cfg_vec))
      |-> (int'($past(cnt_q)) == period_of($past(act_base3), $past(act_exp)) - 1));

   always @(posedge clk) begin
      if (!rst_n && carrier_mode) begin
         assert_low_in_reset_R10: assert (!pin_out)
            else $error("pin high during reset in carrier mode");
      end
   end

endmodule

bind ircg_carrier_gen ircg_carrier_gen_chk #(.EXP_W(EXP_W), .CNT_W(CNT_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .carrier_mode (carrier_mode),
   .data_en      (data_en),
   .pin_out      (pin_out),
   .cnt_q        (cnt_q),
   .act_base3    (act_base3),
   .act_exp      (act_exp),
   .act_third    (act_third)
);

// File: tb/ircg_carrier_gen_tb_top.sv
module ircg_carrier_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int EXP_W      = 2;
   localparam int NVEC       = 12;

   // vector layout: {base3, exp[1:0], third}
   localparam logic [3:0] VEC [NVEC] = '{
      4'b0_00_0, 4'b0_01_1, 4'b0_10_0, 4'b0_11_1,
      4'b1_00_0, 4'b1_00_1, 4'b1_01_1, 4'b1_01_0,
      4'b1_10_1, 4'b1_11_0, 4'b1_11_1, 4'b0_11_0
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             div_base3;
   logic [EXP_W-1:0] div_exp;
   logic             duty_third;
   logic             carrier_mode;
   logic             data_en;
   logic             pin_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ircg_carrier_gen #(.EXP_W(EXP_W)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .div_base3    (div_base3),
      .div_exp      (div_exp),
      .duty_third   (duty_third),
      .carrier_mode (carrier_mode),
      .data_en      (data_en),
      .pin_out      (pin_out)
   );

   function automatic int exp_period(input bit b3, input int e);
      return (b3 ? 3 : 2) << e;
   endfunction

   function automatic int exp_high(input bit b3, input int e, input bit t);
      if (!b3)    return 1 << e;
      if (e == 0) return 1;
      return t ? (1 << e) : (3 << (e - 1));
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: pin_out=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R10: reset holds pin low in carrier mode even with data high
      rst_n        = 1'b0;
      div_base3    = 1'b0;
      div_exp      = '0;
      duty_third   = 1'b0;
      carrier_mode = 1'b1;
      data_en      = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(pin_out, 1'b0, "R10 reset");
      end
      step();
      rst_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(pin_out, (k % 2) == 0, "R10 first burst");
      end

      // Table walk: R1 period plus R2..R6 duty per ratio
      for (int v = 0; v < NVEC; v++) begin
         bit    b3;
         int    e;
         bit    t;
         int    per;
         int    hi;
         string tag;
         b3 = VEC[v][3];
         e  = int'(VEC[v][2:1]);
         t  = VEC[v][0];
         per = exp_period(b3, e);
         hi  = exp_high(b3, e, t);
         if (!b3)         tag = t ? "R1 R6" : "R1 R2";
         else if (e == 0) tag = "R1 R3";
         else             tag = t ? "R1 R4" : "R1 R5";
         step();
         data_en    = 1'b0;
         div_base3  = b3;
         div_exp    = EXP_W'(e);
         duty_third = t;
         step();
         data_en = 1'b1;
         for (int k = 0; k < 2 * per; k++) begin
            @(negedge clk);
            check(pin_out, (k % per) < hi, tag);
            if (k < 2 * per - 1) step();
         end
      end

      // R7: gate drop mid-burst, then restart at phase 0 (ratio 8, high 4)
      step();
      data_en    = 1'b0;
      div_base3  = 1'b0;
      div_exp    = 2'd2;
      duty_third = 1'b0;
      step();
      data_en = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(pin_out, k < 4, "R7 pre-drop");
         step();
      end
      data_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(pin_out, 1'b0, "R7 gate low");
         step();
      end
      data_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check(pin_out, k < 4, "R7 restart");
         step();
      end

      // R9: ratio 4 running, switch to ratio 3 during first period
      data_en   = 1'b0;
      div_base3 = 1'b0;
      div_exp   = 2'd1;
      step();
      data_en = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check(pin_out, (k < 4) ? (k < 2) : (((k - 4) % 3) == 0), "R9");
         step();
         if (k == 1) begin
            div_base3 = 1'b1;
            div_exp   = 2'd0;
         end
      end

      // R8: level mode passes data straight through
      carrier_mode = 1'b0;
      div_base3    = 1'b1;
      div_exp      = 2'd3;
      for (int k = 0; k < 8; k++) begin
         data_en = (k % 3) != 1;
         @(negedge clk);
         check(pin_out, (k % 3) != 1, "R8");
         step();
      end

      finish_run();
   end

endmodule